// File: doc/BRIEF.md
# Data-Driven Clock-Gated Register Bank

This block is a parameterised bank of storage flops split into equal groups. Each group takes its clock from its own glitch-free gating cell. The gating enable is computed in hardware: the incoming data slice is compared bit by bit with the stored slice, and the group's clock is let through only in a cycle where at least one bit would change. A software enable input can force every group to be clocked. Reset forces every group to be clocked so that the bank clears even when the data input already equals the stored value.

The gating cell has two forms, chosen by a parameter. In the first, a latch that is open during the low phase of the clock feeds an AND gate, so an idle gated clock stays low. In the second, a latch that is open during the high phase feeds an OR gate through an inverter, so an idle gated clock stays high. Either way, an enable that moves while the latch is closed cannot reach the gated clock. The gated clocks are brought out so that gating activity can be observed.

Data and the software enable must settle during the high phase of the source clock that comes before the capturing rising edge. This is the window both latch forms sample in.

Top module: `cg_regbank`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, every group receives a gated clock pulse and `q_out` becomes all zeros one edge later, even when `d_in` already equals `q_out`.
- R2: With `rst` low, `q_out` after each rising edge of `clk` equals the `d_in` value that was held before that edge, exactly like a register clocked on every edge.
- R3: Group g covers bits `[g*GROUP_W +: GROUP_W]` of `d_in`/`q_out` and `gclk_out[g]`. It gets a rising gated-clock edge at a `clk` rising edge if and only if `rst` or `sw_en` is high, or its data slice differs in at least one bit from its stored slice.
- R4: A group whose data slice equals its stored slice, with `sw_en` and `rst` low, produces no gated-clock edge and its stored value does not change.
- R5: When `sw_en` is high, every group is clocked whatever the data.
- R6: With the AND style (`STYLE` = 0), `gclk_out` is low whenever `clk` is low, and a disabled group's `gclk_out` stays low.
- R7: With the OR style (`STYLE` = 1), `gclk_out` is high whenever `clk` is high, and a disabled group's `gclk_out` stays high.
- R8: No high or low level on any `gclk_out` bit lasts less than one half period of `clk`.
- R9: A data or `sw_en` excursion that begins and ends inside the high phase of `clk` causes no gated-clock pulse and no change to `q_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running source clock |
| rst | input | 1 | Synchronous active-high reset; forces clocking and loads zero |
| sw_en | input | 1 | Software enable; forces every group to be clocked |
| d_in | input | WIDTH | Next data for the bank |
| q_out | output | WIDTH | Stored data |
| gclk_out | output | GROUPS | Per-group gated clock, for observation |

## Verification
The hardest case to reach from the ports is an enable that moves while the gating latch is closed. This can only be created by moving data or the software enable and moving it back inside one high phase. The bench drives such excursions at sub-phase offsets after a rising edge and confirms that no gated edge and no data change follow. A second instance of the other gating style shares the same stimulus, so the two latch forms are stressed with the same short excursions. Every level on every gated clock is timed against a half period to catch slivers.

// File: rtl/cg_regbank_pkg.sv
`timescale 1ns/1ps
package cg_regbank_pkg;

    // Gating cell flavour: which latch phase and which output gate
    typedef enum logic {
        GATE_LATCH_AND = 1'b0,   // low-transparent latch, AND gate, idle low
        GATE_LATCH_OR  = 1'b1    // high-transparent latch, OR gate, idle high
    } gate_style_e;

    // Reasons a group may need a clock edge this cycle
    typedef struct packed {
        logic force_on;    // reset or software request
        logic data_moved;  // at least one bit of the slice differs
    } gate_req_t;

    function automatic logic req_to_enable(input gate_req_t req);
        return req.force_on | req.data_moved;
    endfunction

endpackage

// File: rtl/cg_enable_gen.sv
`timescale 1ns/1ps
module cg_enable_gen
    import cg_regbank_pkg::*;
#(
    parameter int GROUP_W = 4
) (
    input  logic               rst,
    input  logic               sw_en,
    input  logic [GROUP_W-1:0] next_val,
    input  logic [GROUP_W-1:0] cur_val,
    output logic               clk_en
);

    gate_req_t req;

    // Per-bit difference, reduced to one request per group
    always_comb begin
        req.force_on   = rst | sw_en;
        req.data_moved = |(next_val ^ cur_val);
        clk_en         = req_to_enable(req);
    end

endmodule

// File: rtl/cg_gate_cell.sv
`timescale 1ns/1ps
module cg_gate_cell
    import cg_regbank_pkg::*;
#(
    parameter gate_style_e STYLE = GATE_LATCH_AND
) (
    input  logic clk,
    input  logic en,
    output logic gclk
);

    logic en_held;

    generate
        if (STYLE == GATE_LATCH_AND) begin : g_and_style
            // Open while the clock is low; closed across the high phase
            always_latch begin
                if (!clk) en_held = en;
            end
            assign gclk = clk & en_held;
        end else begin : g_or_style
            // Open while the clock is high; closed across the low phase
            always_latch begin
                if (clk) en_held = en;
            end
            assign gclk = clk | ~en_held;
        end
    endgenerate

endmodule

// File: rtl/cg_group_reg.sv
`timescale 1ns/1ps
module cg_group_reg #(
    parameter int GROUP_W = 4
) (
    input  logic               gclk,
    input  logic               rst,
    input  logic [GROUP_W-1:0] d,
    output logic [GROUP_W-1:0] q
);

    // Reset is sampled on the gated edge; the enable forces that edge
    always_ff @(posedge gclk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/cg_regbank.sv
`timescale 1ns/1ps
module cg_regbank
    import cg_regbank_pkg::*;
#(
    parameter int          WIDTH  = 16,
    parameter int          GROUPS = 4,
    parameter gate_style_e STYLE  = GATE_LATCH_AND
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_en,
    input  logic [WIDTH-1:0]  d_in,
    output logic [WIDTH-1:0]  q_out,
    output logic [GROUPS-1:0] gclk_out
);

    localparam int GROUP_W = WIDTH / GROUPS;

    logic [GROUPS-1:0] grp_en;

    generate
        for (genvar g = 0; g < GROUPS; g++) begin : g_group
            cg_enable_gen #(.GROUP_W(GROUP_W)) u_en (
                .rst      (rst),
                .sw_en    (sw_en),
                .next_val (d_in [g*GROUP_W +: GROUP_W]),
                .cur_val  (q_out[g*GROUP_W +: GROUP_W]),
                .clk_en   (grp_en[g])
            );

            cg_gate_cell #(.STYLE(STYLE)) u_cg (
                .clk  (clk),
                .en   (grp_en[g]),
                .gclk (gclk_out[g])
            );

            cg_group_reg #(.GROUP_W(GROUP_W)) u_reg (
                .gclk (gclk_out[g]),
                .rst  (rst),
                .d    (d_in [g*GROUP_W +: GROUP_W]),
                .q    (q_out[g*GROUP_W +: GROUP_W])
            );
        end
    endgenerate

endmodule

// File: rtl/cg_regbank_chk.sv
`timescale 1ns/1ps
module cg_regbank_chk
    import cg_regbank_pkg::*;
#(
    parameter int          WIDTH  = 16,
    parameter int          GROUPS = 4,
    parameter gate_style_e STYLE  = GATE_LATCH_AND
) (
    input logic              clk,
    input logic              rst,
    input logic              sw_en,
    input logic [WIDTH-1:0]  d_in,
    input logic [WIDTH-1:0]  q_out,
    input logic [GROUPS-1:0] gclk_out
);

    // Ungated shadow register clocked on every source edge
    logic [WIDTH-1:0] shadow_q;
    always_ff @(posedge clk) begin
        if (rst) shadow_q <= '0;
        else     shadow_q <= d_in;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (q_out == '0));

    assert_matches_ungated_R2: assert property (@(posedge clk) disable iff (rst)
        q_out == shadow_q);

    assert_idle_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (!sw_en && (d_in == q_out)) |=> $stable(q_out));

    assert_sw_forces_load_R5: assert property (@(posedge clk) disable iff (rst)
        sw_en |=> (q_out == $past(d_in)));

    generate
        for (genvar g = 0; g < GROUPS; g++) begin : g_lvl
            if (STYLE == GATE_LATCH_AND) begin : g_and
                // Sampled just before the rising edge: low phase of clk
                assert_and_low_in_low_phase_R6: assert property (@(posedge clk) disable iff (rst)
                    gclk_out[g] == 1'b0);
            end else begin : g_or
                // Sampled just before the falling edge: high phase of clk
                assert_or_high_in_high_phase_R7: assert property (@(negedge clk) disable iff (rst)
                    gclk_out[g] == 1'b1);
            end
        end
    endgenerate

endmodule

bind cg_regbank cg_regbank_chk #(
    .WIDTH  (WIDTH),
    .GROUPS (GROUPS),
    .STYLE  (STYLE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sw_en    (sw_en),
    .d_in     (d_in),
    .q_out    (q_out),
    .gclk_out (gclk_out)
);

// File: tb/tb_cg_regbank.sv
`timescale 1ns/1ps
module tb_cg_regbank;
    import cg_regbank_pkg::*;

    localparam int  WIDTH   = 16;
    localparam int  GROUPS  = 4;
    localparam int  GROUP_W = WIDTH / GROUPS;
    localparam real HALF    = 2.0;   // 250 MHz source clock

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sw_en = 1'b0;
    logic [WIDTH-1:0]  d = '0;
    logic [WIDTH-1:0]  q_a, q_o;
    logic [GROUPS-1:0] g_a, g_o;

    int checks = 0;
    int errors = 0;

    always #(HALF) clk = ~clk;

    cg_regbank #(.WIDTH(WIDTH), .GROUPS(GROUPS), .STYLE(GATE_LATCH_AND)) dut (
        .clk(clk), .rst(rst), .sw_en(sw_en), .d_in(d), .q_out(q_a), .gclk_out(g_a));

    cg_regbank #(.WIDTH(WIDTH), .GROUPS(GROUPS), .STYLE(GATE_LATCH_OR)) dut_or (
        .clk(clk), .rst(rst), .sw_en(sw_en), .d_in(d), .q_out(q_o), .gclk_out(g_o));

    // Pulse counters and level-width monitors per gated clock
    logic [31:0] pc_a [GROUPS];
    logic [31:0] pc_o [GROUPS];
    logic [31:0] nw_a [GROUPS];
    logic [31:0] nw_o [GROUPS];

    generate
        for (genvar gi = 0; gi < GROUPS; gi++) begin : g_mon
            int  ca = 0, co = 0, va = 0, vo = 0;
            real ta = -1.0, to = -1.0;
            always @(posedge g_a[gi]) ca++;
            always @(posedge g_o[gi]) co++;
            always @(g_a[gi]) begin
                if (ta >= 0.0 && ($realtime - ta) < HALF - 0.01) va++;
                ta = $realtime;
            end
            always @(g_o[gi]) begin
                if (to >= 0.0 && ($realtime - to) < HALF - 0.01) vo++;
                to = $realtime;
            end
            assign pc_a[gi] = ca;
            assign pc_o[gi] = co;
            assign nw_a[gi] = va;
            assign nw_o[gi] = vo;
        end
    endgenerate

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive in the high phase, check after the next rising edge
    task automatic apply(input logic [WIDTH-1:0] nd, input logic nsw, input logic nrst,
                         input string req);
        logic [WIDTH-1:0] oa, oo;
        logic [31:0] sa [GROUPS];
        logic [31:0] so [GROUPS];
        logic [WIDTH-1:0] exp_q;
        @(posedge clk);
        #0.5;
        oa = q_a; oo = q_o;
        for (int g = 0; g < GROUPS; g++) begin sa[g] = pc_a[g]; so[g] = pc_o[g]; end
        d = nd; sw_en = nsw; rst = nrst;
        @(posedge clk);
        #1.0;
        exp_q = nrst ? '0 : nd;
        check(q_a === exp_q, req, "and-style q", q_a, exp_q);
        check(q_o === exp_q, req, "or-style q",  q_o, exp_q);
        for (int g = 0; g < GROUPS; g++) begin
            logic e_a, e_o;
            e_a = nrst | nsw | (oa[g*GROUP_W +: GROUP_W] !== nd[g*GROUP_W +: GROUP_W]);
            e_o = nrst | nsw | (oo[g*GROUP_W +: GROUP_W] !== nd[g*GROUP_W +: GROUP_W]);
            check((pc_a[g] - sa[g]) == 32'(e_a), "R3", $sformatf("and pulses grp%0d (%s)", g, req),
                  pc_a[g] - sa[g], 64'(e_a));
            check((pc_o[g] - so[g]) == 32'(e_o), "R3", $sformatf("or pulses grp%0d (%s)", g, req),
                  pc_o[g] - so[g], 64'(e_o));
        end
    endtask

    task automatic test_reset();
        apply('0, 1'b0, 1'b1, "R1");
        apply('0, 1'b0, 1'b1, "R1");   // d equals q, reset still clocks every group
        apply(16'hFFFF, 1'b0, 1'b0, "R2");
        apply(16'hFFFF, 1'b0, 1'b1, "R1"); // reset with d==q nonzero
        apply('0, 1'b0, 1'b0, "R1");
    endtask

    task automatic test_single_group();
        apply(16'h0A00, 1'b0, 1'b0, "R3");  // only group 2 moves
        apply(16'h0A01, 1'b0, 1'b0, "R3");  // single bit in group 0
        apply(16'h8A01, 1'b0, 1'b0, "R3");  // top bit, group 3
    endtask

    task automatic test_hold_levels();
        apply(16'h8A01, 1'b0, 1'b0, "R4");  // no change anywhere
        // high phase after the idle edge
        check(g_a == '0,          "R6", "and idle level high phase", g_a, 0);
        check(g_o == '1,          "R7", "or idle level high phase",  g_o, 4'hF);
        #2.0;                              // low phase
        check(g_a == '0,          "R6", "and level low phase", g_a, 0);
        check(g_o == '1,          "R7", "or idle level low phase", g_o, 4'hF);
        check(q_a == 16'h8A01,    "R4", "and hold value", q_a, 16'h8A01);
    endtask

    task automatic test_sw_enable();
        apply(16'h8A01, 1'b1, 1'b0, "R5");  // same data, forced clocks
        apply(16'h1234, 1'b1, 1'b0, "R5");
        apply(16'h1234, 1'b0, 1'b0, "R4");
    endtask

    task automatic test_glitch();
        logic [31:0] sa [GROUPS];
        logic [31:0] so [GROUPS];
        @(posedge clk);
        #0.2;
        for (int g = 0; g < GROUPS; g++) begin sa[g] = pc_a[g]; so[g] = pc_o[g]; end
        #0.3; d = 16'hEDCB;
        #0.4; d = 16'h1234;
        #0.2; sw_en = 1'b1;
        #0.3; sw_en = 1'b0;
        @(posedge clk);
        #1.0;
        for (int g = 0; g < GROUPS; g++) begin
            check(pc_a[g] == sa[g], "R9", $sformatf("and glitch pulses grp%0d", g), pc_a[g] - sa[g], 0);
            check(pc_o[g] == so[g], "R9", $sformatf("or glitch pulses grp%0d", g),  pc_o[g] - so[g], 0);
        end
        check(q_a == 16'h1234, "R9", "and q after glitch", q_a, 16'h1234);
        check(q_o == 16'h1234, "R9", "or q after glitch",  q_o, 16'h1234);
    endtask

    task automatic test_sequence();
        logic [15:0] lf = 16'hACE1;
        logic [WIDTH-1:0] cur = 16'h1234;
        for (int i = 0; i < 150; i++) begin
            logic [WIDTH-1:0] mask;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            for (int g = 0; g < GROUPS; g++)
                mask[g*GROUP_W +: GROUP_W] = lf[g] ? '1 : '0;
            cur = cur ^ (lf & mask);
            apply(cur, lf[0] & lf[7] & lf[9], 1'b0, "R2");
        end
    endtask

    task automatic test_widths();
        for (int g = 0; g < GROUPS; g++) begin
            check(nw_a[g] == 0, "R8", $sformatf("and short levels grp%0d", g), nw_a[g], 0);
            check(nw_o[g] == 0, "R8", $sformatf("or short levels grp%0d", g),  nw_o[g], 0);
        end
    endtask

    initial begin
        test_reset();
        check(q_a == '0 && q_o == '0, "R1", "reset state", {q_a, q_o}, 0);
        test_single_group();
        test_hold_levels();
        test_sw_enable();
        test_glitch();
        test_sequence();
        test_widths();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule